// File: doc/BRIEF.md
# Bit-Serial Left Shift Unit

This unit performs a logical left shift of a 32-bit operand by stepping one bit position per clock under a 5-bit down-counter. A pulse on `start` captures three operands: a 5-bit immediate count, a 5-bit count taken from a second register operand, and the data word. The immediate count is used when it is nonzero. When the immediate is zero, the register-supplied count is used instead. The unit loads the data into its result register and shifts it left once per clock, feeding zeros into bit 0, until the counter reaches zero. It then raises `done` for a single cycle. The result stays on `result` until the next accepted operation.

A controller with five named states sequences the work:
- `ST_IDLE` waits for `start`. On the transition `IDLE->ALT`, taken on `start`, it loads the counter from the immediate and latches the operands.
- `ST_ALT` reloads the counter from the register count if the counter is zero. Its transition is `ALT->LOAD`.
- `ST_LOAD` copies the data word into the result register. Its transition is `LOAD->SHIFT`.
- `ST_SHIFT` shifts and decrements while the counter is nonzero. It takes `SHIFT->SHIFT` while the counter is nonzero and `SHIFT->DONE` once it is zero.
- `ST_DONE` drives `done`. Its transition is `DONE->IDLE`.

The `neqz` output reports whether the counter is nonzero. Register-file access and instruction decode are outside the unit.

Top module: `bit_serial_lshift`

## Requirements
- R1: After reset, `result` is 0, `done` is 0 and `neqz` is 0.
- R2: With a nonzero immediate count k, the final `result` equals the captured data shifted left by k, with zeros in the vacated low bits, and the register count has no effect.
- R3: With an immediate count of 0, the shift amount is the register count `reg_cnt`.
- R4: When the immediate count and the register count are both 0, `result` equals the captured data unchanged.
- R5: If `start` is sampled at clock edge E0 and the effective count is n, `done` is high only in the cycle following edge E(3+n), for exactly one cycle.
- R6: `neqz` is high exactly while the internal count is nonzero. Over one operation, the number of cycles with `neqz` high has one of three values:
  - n+2 when the immediate count is nonzero.
  - n+1 when the immediate is 0 and the register count n is nonzero.
  - 0 when both counts are 0.
- R7: A `start` sampled in any state other than `ST_IDLE` has no effect. The operation in progress keeps its result and latency, and no extra `done` follows.
- R8: Operands are captured at the edge that accepts `start`. Later changes to `imm_cnt`, `reg_cnt` or `data_in` do not affect the operation in progress.
- R9: `result` holds its value from `done` until the next accepted operation loads new data.
- R10: A count of 31, from either source, leaves only the original bit 0 in bit 31 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation, sampled in `ST_IDLE` only |
| imm_cnt | input | 5 | Immediate shift count |
| reg_cnt | input | 5 | Register-supplied shift count, used when `imm_cnt` is 0 |
| data_in | input | 32 | Data operand to shift |
| result | output | 32 | Shifted value, held after completion |
| done | output | 1 | One-cycle pulse when `result` is final |
| neqz | output | 1 | High while the shift counter is nonzero |

## Verification
The collision that matters is a new `start` that arrives while an operation is running. It can land in the same cycle as the counter fallback, in the same cycle as a shift step, or in the same cycle as `done`. The bench raises a second request at chosen offsets in each of these three cases and scrambles the operand inputs at the same time. The scoreboard then confirms three things: the first operation's result and latency are unchanged, no second `done` appears, and `result` stays put afterwards.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALT,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE
    } lsh_state_e;
endpackage

// File: rtl/lsh_ctrl.sv
module lsh_ctrl
    import lsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cnt_nz,
    output lsh_state_e state,
    output logic       take,
    output logic       alt_ld,
    output logic       data_ld,
    output logic       step,
    output logic       done
);
    lsh_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_ALT;
            ST_ALT:   nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_SHIFT;
            ST_SHIFT: if (!cnt_nz) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        take    = 1'b0;
        alt_ld  = 1'b0;
        data_ld = 1'b0;
        step    = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:  take    = start;
            ST_ALT:   alt_ld  = 1'b1;
            ST_LOAD:  data_ld = 1'b1;
            ST_SHIFT: step    = cnt_nz;
            ST_DONE:  done    = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/lsh_counter.sv
module lsh_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             alt_ld,
    input  logic             step,
    input  logic [CNT_W-1:0] imm_val,
    input  logic [CNT_W-1:0] reg_val,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_nz
);
    logic [CNT_W-1:0] reg_hold;

    assign cnt_nz = |cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            reg_hold <= '0;
        end else if (take) begin
            cnt      <= imm_val;
            reg_hold <= reg_val;
        end else if (alt_ld && !cnt_nz) begin
            cnt <= reg_hold;
        end else if (step) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/lsh_datapath.sv
module lsh_datapath #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              data_ld,
    input  logic              step,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] data_hold;
    logic [DATA_W-1:0] shifted;

    assign shifted[0] = 1'b0;
    for (genvar i = 1; i < DATA_W; i++) begin : g_lane
        assign shifted[i] = q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_hold <= '0;
            q         <= '0;
        end else begin
            if (take)         data_hold <= data_in;
            if (data_ld)      q <= data_hold;
            else if (step)    q <= shifted;
        end
    end
endmodule

// File: rtl/bit_serial_lshift.sv
module bit_serial_lshift
    import lsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  imm_cnt,
    input  logic [CNT_W-1:0]  reg_cnt,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] result,
    output logic              done,
    output logic              neqz
);
    lsh_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_nz, take, alt_ld, data_ld, step;

    lsh_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_nz(cnt_nz),
        .state(state), .take(take), .alt_ld(alt_ld), .data_ld(data_ld),
        .step(step), .done(done)
    );

    lsh_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .take(take), .alt_ld(alt_ld), .step(step),
        .imm_val(imm_cnt), .reg_val(reg_cnt), .cnt(cnt), .cnt_nz(cnt_nz)
    );

    lsh_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .take(take), .data_ld(data_ld), .step(step),
        .data_in(data_in), .q(result)
    );

    assign neqz = cnt_nz;
endmodule

// File: rtl/lsh_checker.sv
module lsh_checker
    import lsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input lsh_state_e        state,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] result,
    input logic              done,
    input logic              neqz
);
    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && neqz) |=> result == {$past(result[DATA_W-2:0]), 1'b0});

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && neqz) |=> cnt == CNT_W'($past(cnt) - CNT_W'(1)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_SHIFT && !neqz));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> state != ST_ALT);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(result));
endmodule

bind bit_serial_lshift lsh_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state), .cnt(cnt),
    .result(result), .done(done), .neqz(neqz)
);

// File: tb/test_bit_serial_lshift.sv
`timescale 1ns/1ps
module test_bit_serial_lshift;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  imm_cnt = '0;
    logic [4:0]  reg_cnt = '0;
    logic [31:0] data_in = '0;
    logic [31:0] result;
    logic        done, neqz;

    always #2 clk = ~clk;   // 250 MHz

    bit_serial_lshift i_bit_serial_lshift (
        .clk(clk), .rst_n(rst_n), .start(start), .imm_cnt(imm_cnt),
        .reg_cnt(reg_cnt), .data_in(data_in), .result(result),
        .done(done), .neqz(neqz)
    );

    typedef struct {
        logic [31:0] res;
        int          lat;
        int          nz;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0, n_bad = 0;
    int   cyc = 0, raise_cyc = 0, nz_seen = 0;
    bit   pending = 0;
    logic [31:0] last_res = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items on done
    always @(negedge clk) begin
        if (rst_n) begin
            if (pending) nz_seen += int'(neqz);
            if (done) begin
                if (sb.size() == 0) begin
                    chk(0, "R7", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(result == e.res, e.tag, "result", result, e.res);
                    chk((cyc - raise_cyc - 1) == e.lat, "R5", "latency",
                        32'(cyc - raise_cyc - 1), 32'(e.lat));
                    chk(nz_seen == e.nz, "R6", "neqz cycles",
                        32'(nz_seen), 32'(e.nz));
                    last_res = e.res;
                end
                pending = 0;
            end
        end
    end

    // driver: intrude < 0 means no second request
    task automatic run(input logic [4:0] imm, input logic [4:0] rc,
                       input logic [31:0] d, input int intrude, input string tag);
        exp_t e;
        int   n;
        n = (imm != 0) ? int'(imm) : int'(rc);
        e.res = d << n;
        e.lat = 3 + n;
        e.nz  = (imm != 0) ? n + 2 : ((n == 0) ? 0 : n + 1);
        e.tag = tag;
        @(posedge clk); #1;
        imm_cnt = imm; reg_cnt = rc; data_in = d; start = 1'b1;
        raise_cyc = cyc; nz_seen = 0; pending = 1;
        sb.push_back(e);
        @(posedge clk); #1;
        start = 1'b0;
        // R8: scramble operands after capture
        imm_cnt = ~imm; reg_cnt = ~rc; data_in = ~d;
        if (intrude >= 0) begin
            repeat (intrude) @(posedge clk);
            #1;
            start = 1'b1; imm_cnt = 5'd3; data_in = 32'hA5A5_5A5A;
            @(posedge clk); #1;
            start = 1'b0;
        end
        wait (!pending);
        repeat (4) @(negedge clk);
        // R9: held after done, and no late restart
        chk(result == e.res, "R9", "held result", result, e.res);
        chk(done == 1'b0, "R9", "done idle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(result == 32'd0, "R1", "reset result", result, 32'd0);
        chk(done == 1'b0, "R1", "reset done", 32'(done), 32'd0);
        chk(neqz == 1'b0, "R1", "reset neqz", 32'(neqz), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(5'd5,  5'd9,  32'h0000_0001, -1, "R2");
        run(5'd1,  5'd0,  32'hFFFF_FFFF, -1, "R2");
        run(5'd12, 5'd31, 32'h1357_9BDF, -1, "R2");
        run(5'd31, 5'd4,  32'hFFFF_FFFF, -1, "R10");
        run(5'd0,  5'd7,  32'h1234_5678, -1, "R3");
        run(5'd0,  5'd31, 32'h0000_0003, -1, "R10");
        run(5'd0,  5'd1,  32'h8000_0001, -1, "R3");
        run(5'd0,  5'd0,  32'hDEAD_BEEF, -1, "R4");
        // R7: second request in fallback cycle, mid-shift, and done cycle
        run(5'd0,  5'd2,  32'h0F0F_0F0F, 0, "R7");
        run(5'd6,  5'd0,  32'h0000_00FF, 2, "R7");
        run(5'd4,  5'd0,  32'h0000_0C01, 7, "R7");
        run(5'd0,  5'd0,  32'h0000_1111, 3, "R7");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R7", "queue drained", 32'(sb.size()), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule